// File: doc/BRIEF.md
# AXI3 Incrementing Burst Master

This block drives one AXI3 bus master port from a simple local command interface. A user issues a command with a start address, a beat count, a transaction ID and a direction. For a write, the user then supplies the data beats through a valid/ready pair. For a read, the block returns each received beat on a registered output with a last-beat marker. Every transaction ends with a one-cycle completion pulse and an error flag.

Only incrementing bursts of full 32-bit words are produced. There is one transaction in flight at a time. Write and read each have their own state machine, and the two never run together. Before a transaction counts as clean, the ID returned on the response or read data channel is compared against the ID that was issued.

Top module: `axi3_burst_master`

## Requirements
- R1: A command is taken on a cycle where `cmdValid` and `cmdReady` are both high. `cmdReady` is high only when both state machines are idle, and `busy` equals its inverse. In the cycle after acceptance `busy` is 1.
- R2: The address channel of the chosen direction raises VALID the cycle after acceptance. It holds VALID, the address, the ID and LEN (= beats-1) unchanged until READY is seen. BURST is 2'b01, SIZE is 3'b010, and LOCK, CACHE and PROT are 0.
- R3: Write beats go out in the order the user supplied them. WDATA and WVALID stay steady while WREADY is low. WID equals AWID and WSTRB is 4'b1111, where bit n enables byte lane n.
- R4: WLAST is high only on beat number LEN+1 of the burst, and on no other beat.
- R5: BREADY is high in the cycle after the last write beat is accepted. `done` pulses for exactly one cycle, in the cycle after the write response handshake.
- R6: After the read address is accepted, RREADY stays high. Each accepted read beat appears on `rdData` with `rdDataValid` one cycle later, and `rdLast` mirrors RLAST. After the handshake of a beat with RLAST high, `done` pulses in the next cycle.
- R7: A response code of 2'b10 or 2'b11 on BRESP, or on any RRESP beat, sets `error`, shown alongside `done`. A BID or RID that differs from the issued ID does the same. Codes 2'b00 and 2'b01 with a matching ID give `error` = 0. The flag is cleared when the next command is accepted.
- R8: A command presented while busy is ignored. No second address channel raises VALID, and the write and read channels are never active together.
- R9: After reset: `busy` is 0, `cmdReady` is 1, `done` is 0, and AWVALID, WVALID and ARVALID are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Command can be taken (idle) |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | 32 | Burst start address |
| cmdLen | input | 4 | Beats minus one |
| cmdId | input | 4 | Transaction ID |
| wrData | input | 32 | User write beat |
| wrDataValid | input | 1 | User write beat present |
| wrDataReady | output | 1 | Write beat taken this cycle |
| rdData | output | 32 | Returned read beat |
| rdDataValid | output | 1 | Read beat present |
| rdLast | output | 1 | Last read beat of the burst |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Completion pulse |
| error | output | 1 | Transaction error, valid with done |
| awId | output | 4 | Write address ID |
| awAddr | output | 32 | Write address |
| awLen | output | 4 | Write burst length |
| awSize | output | 3 | Write beat size |
| awBurst | output | 2 | Write burst type |
| awLock | output | 2 | Write lock type |
| awCache | output | 4 | Write cache type |
| awProt | output | 3 | Write protection type |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| wId | output | 4 | Write data ID |
| wData | output | 32 | Write data |
| wStrb | output | 4 | Write byte strobes |
| wLast | output | 1 | Final write beat |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| bId | input | 4 | Response ID |
| bResp | input | 2 | Write response code |
| bValid | input | 1 | Response valid |
| bReady | output | 1 | Response ready |
| arId | output | 4 | Read address ID |
| arAddr | output | 32 | Read address |
| arLen | output | 4 | Read burst length |
| arSize | output | 3 | Read beat size |
| arBurst | output | 2 | Read burst type |
| arLock | output | 2 | Read lock type |
| arCache | output | 4 | Read cache type |
| arProt | output | 3 | Read protection type |
| arValid | output | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| rId | input | 4 | Read data ID |
| rData | input | 32 | Read data |
| rResp | input | 2 | Read response code |
| rLast | input | 1 | Final read beat |
| rValid | input | 1 | Read data valid |
| rReady | output | 1 | Read data ready |

## Verification
Bursts of one, four and sixteen beats are run in both directions. A single-beat burst tells the first beat apart from the last. A sixteen-beat burst exercises the full LEN field and the beat counter wrap. Writes are run twice: once with WREADY always high, which checks the back-to-back loading path, and once with a stalling WREADY and a delayed AWREADY, which checks that data holds and beats stay in order under backpressure. Responses are varied across OKAY, EXOKAY, SLVERR and DECERR, with a flipped BID or RID, and with the bad RRESP placed on a middle beat. This separates the real error sources from benign codes and shows that the flag clears on the next command. A read command presented during a write checks that the block is deaf while busy.

// File: rtl/abm_pkg.sv
package abm_pkg;

  localparam logic [1:0] BURST_INCR = 2'b01;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_ADDR,
    WR_DATA,
    WR_RESP
  } wrState_e;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_ADDR,
    RD_DATA
  } rdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCmd;
    logic loadBeat;
    logic checkB;
    logic takeR;
  } dpCtrl_t;

endpackage

// File: rtl/abm_ctrl.sv
module abm_ctrl
  import abm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    cmdWrite,
  input  logic    wrDataValid,
  input  logic    awReady,
  input  logic    wReady,
  input  logic    bValid,
  input  logic    arReady,
  input  logic    rValid,
  input  logic    rLast,
  input  logic    wLastQ,
  input  logic    allLoaded,
  output logic    cmdReady,
  output logic    busy,
  output logic    wrDataReady,
  output logic    awValid,
  output logic    wValid,
  output logic    bReady,
  output logic    arValid,
  output logic    rReady,
  output logic    done,
  output dpCtrl_t ctl
);

  wrState_e wrQ;
  rdState_e rdQ;
  logic awValidQ, wValidQ, arValidQ, doneQ;
  logic idle, accept, wHs;

  assign idle        = (wrQ == WR_IDLE) && (rdQ == RD_IDLE);
  assign cmdReady    = idle;
  assign busy        = !idle;
  assign accept      = cmdValid && idle;
  assign wHs         = wValidQ && wReady;
  assign wrDataReady = (wrQ == WR_DATA) && (!wValidQ || wReady) && !allLoaded;
  assign bReady      = (wrQ == WR_RESP);
  assign rReady      = (rdQ == RD_DATA);

  assign ctl.latchCmd = accept;
  assign ctl.loadBeat = wrDataReady && wrDataValid;
  assign ctl.checkB   = bReady && bValid;
  assign ctl.takeR    = rReady && rValid;

  assign awValid = awValidQ;
  assign wValid  = wValidQ;
  assign arValid = arValidQ;
  assign done    = doneQ;

  // write state machine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrQ      <= WR_IDLE;
      awValidQ <= 1'b0;
      wValidQ  <= 1'b0;
    end else begin
      case (wrQ)
        WR_IDLE: if (accept && cmdWrite) begin
          wrQ      <= WR_ADDR;
          awValidQ <= 1'b1;
        end
        WR_ADDR: if (awReady) begin
          wrQ      <= WR_DATA;
          awValidQ <= 1'b0;
        end
        WR_DATA: if (wHs && wLastQ) wrQ <= WR_RESP;
        WR_RESP: if (ctl.checkB) wrQ <= WR_IDLE;
        default: wrQ <= WR_IDLE;
      endcase
      if (ctl.loadBeat)  wValidQ <= 1'b1;
      else if (wHs)      wValidQ <= 1'b0;
    end
  end

  // read state machine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ      <= RD_IDLE;
      arValidQ <= 1'b0;
    end else begin
      case (rdQ)
        RD_IDLE: if (accept && !cmdWrite) begin
          rdQ      <= RD_ADDR;
          arValidQ <= 1'b1;
        end
        RD_ADDR: if (arReady) begin
          rdQ      <= RD_DATA;
          arValidQ <= 1'b0;
        end
        RD_DATA: if (ctl.takeR && rLast) rdQ <= RD_IDLE;
        default: rdQ <= RD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= ctl.checkB || (ctl.takeR && rLast);
  end

  p_cmd_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> busy);
  p_aw_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady) |=> awValid);
  p_ar_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && !arReady) |=> arValid);
  p_w_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && !wReady) |=> wValid);
  p_resp_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && wReady && wLastQ) |=> bReady);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_one_dir_r8: assert property (@(posedge clk) disable iff (!rstN)
    !((awValid || wValid || bReady) && (arValid || rReady)));

endmodule

// File: rtl/abm_datapath.sv
module abm_datapath
  import abm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [ID_W-1:0]   cmdId,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ID_W-1:0]   bId,
  input  logic [1:0]        bResp,
  input  logic [ID_W-1:0]   rId,
  input  logic [DATA_W-1:0] rData,
  input  logic [1:0]        rResp,
  input  logic              rLast,
  output logic [ADDR_W-1:0] addrQ,
  output logic [LEN_W-1:0]  lenQ,
  output logic [ID_W-1:0]   idQ,
  output logic [DATA_W-1:0] wDataQ,
  output logic              wLastQ,
  output logic              allLoaded,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataValid,
  output logic              rdLast,
  output logic              error
);

  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] loadCnt;
  logic lastLoad, bBad, rBad, errQ;

  assign lastLoad  = (loadCnt == {1'b0, lenQ});
  assign allLoaded = (loadCnt > {1'b0, lenQ});
  assign bBad      = (bResp >= 2'b10) || (bId != idQ);
  assign rBad      = (rResp >= 2'b10) || (rId != idQ);
  assign error     = errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      lenQ    <= '0;
      idQ     <= '0;
      loadCnt <= '0;
      wDataQ  <= '0;
      wLastQ  <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      if (ctl.latchCmd) begin
        addrQ   <= cmdAddr;
        lenQ    <= cmdLen;
        idQ     <= cmdId;
        loadCnt <= '0;
        wLastQ  <= 1'b0;
        errQ    <= 1'b0;
      end else begin
        if (ctl.loadBeat) begin
          wDataQ  <= wrData;
          wLastQ  <= lastLoad;
          loadCnt <= loadCnt + 1'b1;
        end
        if ((ctl.checkB && bBad) || (ctl.takeR && rBad)) errQ <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData      <= '0;
      rdDataValid <= 1'b0;
      rdLast      <= 1'b0;
    end else begin
      rdDataValid <= ctl.takeR;
      rdLast      <= ctl.takeR && rLast;
      if (ctl.takeR) rdData <= rData;
    end
  end

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchCmd |=> !error);
  p_rd_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeR |=> rdDataValid);
  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadBeat |-> !allLoaded);

endmodule

// File: rtl/axi3_burst_master.sv
module axi3_burst_master
  import abm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [ID_W-1:0]   cmdId,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrDataValid,
  output logic              wrDataReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataValid,
  output logic              rdLast,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ID_W-1:0]   awId,
  output logic [ADDR_W-1:0] awAddr,
  output logic [LEN_W-1:0]  awLen,
  output logic [2:0]        awSize,
  output logic [1:0]        awBurst,
  output logic [1:0]        awLock,
  output logic [3:0]        awCache,
  output logic [2:0]        awProt,
  output logic              awValid,
  input  logic              awReady,
  output logic [ID_W-1:0]   wId,
  output logic [DATA_W-1:0] wData,
  output logic [DATA_W/8-1:0] wStrb,
  output logic              wLast,
  output logic              wValid,
  input  logic              wReady,
  input  logic [ID_W-1:0]   bId,
  input  logic [1:0]        bResp,
  input  logic              bValid,
  output logic              bReady,
  output logic [ID_W-1:0]   arId,
  output logic [ADDR_W-1:0] arAddr,
  output logic [LEN_W-1:0]  arLen,
  output logic [2:0]        arSize,
  output logic [1:0]        arBurst,
  output logic [1:0]        arLock,
  output logic [3:0]        arCache,
  output logic [2:0]        arProt,
  output logic              arValid,
  input  logic              arReady,
  input  logic [ID_W-1:0]   rId,
  input  logic [DATA_W-1:0] rData,
  input  logic [1:0]        rResp,
  input  logic              rLast,
  input  logic              rValid,
  output logic              rReady
);

  localparam int STRB_W = DATA_W / 8;
  localparam logic [2:0] SIZE_CODE = 3'($clog2(STRB_W));

  dpCtrl_t ctl;
  logic [ADDR_W-1:0] addrQ;
  logic [LEN_W-1:0]  lenQ;
  logic [ID_W-1:0]   idQ;
  logic              wLastQ, allLoaded;

  abm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdWrite   (cmdWrite),
    .wrDataValid(wrDataValid),
    .awReady    (awReady),
    .wReady     (wReady),
    .bValid     (bValid),
    .arReady    (arReady),
    .rValid     (rValid),
    .rLast      (rLast),
    .wLastQ     (wLastQ),
    .allLoaded  (allLoaded),
    .cmdReady   (cmdReady),
    .busy       (busy),
    .wrDataReady(wrDataReady),
    .awValid    (awValid),
    .wValid     (wValid),
    .bReady     (bReady),
    .arValid    (arValid),
    .rReady     (rReady),
    .done       (done),
    .ctl        (ctl)
  );

  abm_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cmdAddr    (cmdAddr),
    .cmdLen     (cmdLen),
    .cmdId      (cmdId),
    .wrData     (wrData),
    .bId        (bId),
    .bResp      (bResp),
    .rId        (rId),
    .rData      (rData),
    .rResp      (rResp),
    .rLast      (rLast),
    .addrQ      (addrQ),
    .lenQ       (lenQ),
    .idQ        (idQ),
    .wDataQ     (wData),
    .wLastQ     (wLastQ),
    .allLoaded  (allLoaded),
    .rdData     (rdData),
    .rdDataValid(rdDataValid),
    .rdLast     (rdLast),
    .error      (error)
  );

  assign awId    = idQ;
  assign awAddr  = addrQ;
  assign awLen   = lenQ;
  assign awSize  = SIZE_CODE;
  assign awBurst = BURST_INCR;
  assign awLock  = '0;
  assign awCache = '0;
  assign awProt  = '0;
  assign wId     = idQ;
  assign wStrb   = '1;
  assign wLast   = wLastQ;
  assign arId    = idQ;
  assign arAddr  = addrQ;
  assign arLen   = lenQ;
  assign arSize  = SIZE_CODE;
  assign arBurst = BURST_INCR;
  assign arLock  = '0;
  assign arCache = '0;
  assign arProt  = '0;

  p_aw_fields_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady) |=> ($stable(awAddr) && $stable(awLen) && $stable(awId)));
  p_ar_fields_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && !arReady) |=> ($stable(arAddr) && $stable(arLen) && $stable(arId)));
  p_wdata_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && !wReady) |=> ($stable(wData) && $stable(wLast)));
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: tb/tb_axi3_burst_master.sv
module tb_axi3_burst_master;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic cmdValid, cmdReady, cmdWrite;
  logic [31:0] cmdAddr;
  logic [3:0] cmdLen, cmdId;
  logic [31:0] wrData;
  logic wrDataValid, wrDataReady;
  logic [31:0] rdData;
  logic rdDataValid, rdLast, busy, done, error;
  logic [3:0] awId, awLen, awCache, wId, bId, arId, arLen, arCache, rId;
  logic [31:0] awAddr, wData, arAddr, rData;
  logic [2:0] awSize, awProt, arSize, arProt;
  logic [1:0] awBurst, awLock, bResp, arBurst, arLock, rResp;
  logic awValid, awReady, wLast, wValid, wReady, bValid, bReady;
  logic arValid, arReady, rLast, rValid, rReady;
  logic [3:0] wStrb;

  axi3_burst_master dut (.*);

  int nChecks = 0;
  int nFails = 0;
  int doneSeen = 0;

  logic [32:0] wExpQ[$];
  logic [32:0] rExpQ[$];
  bit dExpQ[$];

  // expected command, set by the driver
  logic [31:0] expAddr;
  int expBeats;
  logic [3:0] expId;

  // slave behaviour knobs
  int awDelay = 0, arDelay = 0;
  bit wStall = 0, bIdFlip = 0, rIdFlip = 0;
  logic [1:0] cfgBResp = 2'b00, cfgRResp = 2'b00;
  int rErrBeat = -1;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wPat(logic [31:0] a, int i);
    return a ^ (32'h9E37_0000 + 32'(i));
  endfunction
  function automatic logic [31:0] rPat(logic [31:0] a, int i);
    return a ^ (32'h5A5A_0000 + 32'(i * 3));
  endfunction

  // slave model: decides ready/valid at the falling edge for the next rising edge
  initial begin
    int cyc = 0, awWait = 0, arWait = 0, wBeat = 0, rIdx = 0, rN = 0;
    bit bPend = 0, bFire = 0, rStart = 0, rFire = 0, rFireLast = 0;
    logic [31:0] rBase = '0;
    awReady = 0; wReady = 0; bValid = 0; bId = 0; bResp = 0;
    arReady = 0; rValid = 0; rId = 0; rData = 0; rResp = 0; rLast = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (bFire) begin
        chk(done === 1'b1, "R5", "done after B handshake", 32'(done), 1);
        bValid = 0; bFire = 0;
      end
      if (rFire) begin
        chk(rdDataValid === 1'b1, "R6", "rdDataValid after R beat", 32'(rdDataValid), 1);
        if (rFireLast) chk(done === 1'b1, "R6", "done after last R beat", 32'(done), 1);
        rFire = 0;
        rIdx++;
        if (rIdx >= rN) rValid = 0;
      end
      if (bPend && !bValid) begin
        bValid = 1; bPend = 0;
        bId = expId ^ (bIdFlip ? 4'h1 : 4'h0);
        bResp = cfgBResp;
      end
      if (rStart) begin rValid = 1; rStart = 0; end
      if (rValid) begin
        rData = rPat(rBase, rIdx);
        rLast = (rIdx == rN - 1);
        rResp = (rIdx == rErrBeat) ? cfgRResp : 2'b00;
        rId = expId ^ (rIdFlip ? 4'h2 : 4'h0);
      end
      // write address
      awReady = awValid && (awWait >= awDelay);
      if (awValid && !awReady) awWait++;
      if (awValid && awReady) begin
        awWait = 0; wBeat = 0;
        chk(awAddr === expAddr, "R2", "awAddr", awAddr, expAddr);
        chk(awLen === 4'(expBeats - 1), "R2", "awLen", 32'(awLen), 32'(expBeats - 1));
        chk(awId === expId, "R2", "awId", 32'(awId), 32'(expId));
        chk({awBurst, awSize, awLock, awCache, awProt} === {2'b01, 3'b010, 9'd0},
            "R2", "aw burst/size/lock/cache/prot", 32'({awBurst, awSize}), 32'h0A);
      end
      // write data
      wReady = wStall ? (cyc % 3 != 0) : 1'b1;
      if (wValid && wReady) begin
        if (wExpQ.size() == 0) chk(0, "R3", "unexpected W beat", wData, 0);
        else begin
          logic [32:0] e;
          e = wExpQ.pop_front();
          chk(wData === e[31:0], "R3", "wData", wData, e[31:0]);
          chk(wLast === e[32], "R4", "wLast", 32'(wLast), 32'(e[32]));
          chk(wId === expId && wStrb === 4'hF, "R3", "wId/wStrb", {wId, wStrb}, {expId, 4'hF});
          if (wLast) bPend = 1;
        end
        wBeat++;
      end
      if (bValid && bReady) bFire = 1;
      // read address
      arReady = arValid && (arWait >= arDelay);
      if (arValid && !arReady) arWait++;
      if (arValid && arReady) begin
        arWait = 0;
        chk(arAddr === expAddr, "R2", "arAddr", arAddr, expAddr);
        chk(arLen === 4'(expBeats - 1), "R2", "arLen", 32'(arLen), 32'(expBeats - 1));
        chk({arId, arBurst, arSize, arLock, arCache, arProt} === {expId, 2'b01, 3'b010, 9'd0},
            "R2", "ar id/burst/size/lock/cache/prot", 32'({arId, arBurst, arSize}), 32'({expId, 5'h0A}));
        rBase = arAddr; rN = int'(arLen) + 1; rIdx = 0; rStart = 1;
      end
      if (rValid && rReady) begin rFire = 1; rFireLast = rLast; end
    end
  end

  // monitor: pops expectations as results come out
  initial begin
    forever begin
      @(negedge clk);
      if (rdDataValid) begin
        if (rExpQ.size() == 0) chk(0, "R6", "unexpected read beat", rdData, 0);
        else begin
          logic [32:0] e;
          e = rExpQ.pop_front();
          chk(rdData === e[31:0], "R6", "rdData", rdData, e[31:0]);
          chk(rdLast === e[32], "R6", "rdLast", 32'(rdLast), 32'(e[32]));
        end
      end
      if (done) begin
        if (dExpQ.size() == 0) chk(0, "R5", "unexpected done", 1, 0);
        else begin
          bit ee;
          ee = dExpQ.pop_front();
          chk(error === ee, "R7", "error with done", 32'(error), 32'(ee));
        end
        doneSeen++;
      end
    end
  end

  task automatic issue(bit wr, logic [31:0] addr, int n, logic [3:0] id);
    expAddr = addr; expBeats = n; expId = id;
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1; cmdWrite = wr; cmdAddr = addr; cmdLen = 4'(n - 1); cmdId = id;
    @(negedge clk);
    cmdValid = 0;
    chk(busy === 1'b1 && cmdReady === 1'b0, "R1", "busy after accept", {busy, cmdReady}, 32'b10);
  endtask

  task automatic waitDone(int target);
    while (doneSeen < target) @(negedge clk);
  endtask

  task automatic doWrite(logic [31:0] addr, int n, logic [3:0] id, bit expErr, bit intrude);
    int target;
    target = doneSeen + 1;
    for (int i = 0; i < n; i++) wExpQ.push_back({(i == n - 1), wPat(addr, i)});
    dExpQ.push_back(expErr);
    issue(1'b1, addr, n, id);
    if (intrude) begin
      for (int k = 0; k < 3; k++) begin
        cmdValid = 1; cmdWrite = 0; cmdAddr = 32'hDEAD_0000; cmdLen = 4'd2;
        @(negedge clk);
        chk(cmdReady === 1'b0 && arValid === 1'b0, "R8", "read ignored while busy",
            {cmdReady, arValid}, 0);
      end
      cmdValid = 0;
    end
    wrDataValid = 1; wrData = wPat(addr, 0);
    for (int i = 0; i < n; ) begin
      @(negedge clk); #1;
      if (wrDataReady) begin
        @(posedge clk); #1;
        i++;
        if (i < n) wrData = wPat(addr, i);
        else wrDataValid = 0;
      end
    end
    waitDone(target);
  endtask

  task automatic doRead(logic [31:0] addr, int n, logic [3:0] id, bit expErr);
    int target;
    target = doneSeen + 1;
    for (int i = 0; i < n; i++) rExpQ.push_back({(i == n - 1), rPat(addr, i)});
    dExpQ.push_back(expErr);
    issue(1'b0, addr, n, id);
    waitDone(target);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    cmdValid = 0; cmdWrite = 0; cmdAddr = 0; cmdLen = 0; cmdId = 0;
    wrData = 0; wrDataValid = 0;
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R9 reset state
    chk(busy === 0 && cmdReady === 1 && done === 0, "R9", "idle after reset",
        {busy, cmdReady, done}, 3'b010);
    chk(awValid === 0 && wValid === 0 && arValid === 0, "R9", "valids low after reset",
        {awValid, wValid, arValid}, 0);

    doWrite(32'h0000_1000, 4, 4'h3, 0, 0);
    awDelay = 3; wStall = 1;
    doWrite(32'h0000_2000, 16, 4'hA, 0, 0);
    doWrite(32'h0000_3000, 1, 4'h5, 0, 1);
    awDelay = 0; wStall = 0;
    doRead(32'h0001_0000, 4, 4'h6, 0);
    arDelay = 2;
    doRead(32'h0001_4000, 16, 4'hF, 0);
    doRead(32'h0001_8000, 1, 4'h0, 0);
    arDelay = 0;
    // R7 error sources
    cfgBResp = 2'b10; doWrite(32'h0002_0000, 2, 4'h1, 1, 0);
    cfgBResp = 2'b01; doWrite(32'h0002_1000, 3, 4'h2, 0, 0);
    cfgBResp = 2'b00; bIdFlip = 1; doWrite(32'h0002_2000, 2, 4'h4, 1, 0);
    bIdFlip = 0; doWrite(32'h0002_3000, 2, 4'h4, 0, 0);
    cfgRResp = 2'b11; rErrBeat = 2; doRead(32'h0003_0000, 5, 4'h7, 1);
    cfgRResp = 2'b00; rErrBeat = -1; rIdFlip = 1; doRead(32'h0003_1000, 3, 4'h8, 1);
    rIdFlip = 0; doRead(32'h0003_2000, 3, 4'h8, 0);

    repeat (5) @(negedge clk);
    chk(wExpQ.size() == 0 && rExpQ.size() == 0 && dExpQ.size() == 0, "R6",
        "all expectations consumed", 32'(wExpQ.size() + rExpQ.size() + dExpQ.size()), 0);
    chk(busy === 0 && done === 0, "R1", "idle at end", {busy, done}, 0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule